// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Detector

This block watches a group of bidirectional port pins and raises one interrupt request when any pin configured as an input makes an active transition. A single polarity input selects the active transition. At 0 it is high-to-low, and the idle level is high. At 1 it is low-to-high, and the idle level is low. The pins do not act as independent edge detectors. They are merged into one "any input pin is active" level. Once a request has fired, the detector stays disarmed until every participating pin is back at its idle level. It works like a wired-AND or wired-OR change detector that rearms only as a whole group.

The request is sticky and is cleared by a one-cycle acknowledge strobe. Pins whose direction bit is 1 (output) are forced to the idle value and never take part. A change of polarity or direction causes the merged level to be sampled again without producing a request in that cycle. The pin levels must already be synchronised to the clock.

Top module: `pin_change_irq`

## Requirements
- R1: A pin whose direction bit is 1 (output) cannot cause a request, whatever its level does; only pins with direction bit 0 (input) participate.
- R2: With polarity 0, a high-to-low transition on any participating pin while the detector is armed sets `irq_req` at the next rising clock edge.
- R3: With polarity 0, after a request has fired, further falling transitions raise nothing until every participating pin has been high for at least one clock edge.
- R4: With polarity 1, a low-to-high transition on any participating pin while armed sets `irq_req` at the next edge; rearming requires every participating pin to be low for at least one edge.
- R5: Every one of the PORT_W x NUM_PORTS pins (bit index = port x PORT_W + bit) can trigger a request in both polarities.
- R6: Once set, `irq_req` stays high until an acknowledge.
- R7: `irq_ack` high at a clock edge clears `irq_req`; it does not rearm the detector while any participating pin is still at its active level.
- R8: A cycle in which `edge_pol` or `pin_dir` differs from its value at the previous edge raises no request, even if the merged level becomes active. The detector then waits for the idle level before it can fire.
- R9: During reset `irq_req` is 0. A pin that is already active when reset is released does not cause a request; one idle edge is needed before the first request.
- R10: With SET_OVER_ACK = 1, a new trigger and an acknowledge at the same edge leave `irq_req` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | PORT_W*NUM_PORTS | Synchronised pin levels |
| pin_dir | input | PORT_W*NUM_PORTS | Per-pin direction, 1 = output (masked) |
| edge_pol | input | 1 | 0 = falling / idle high, 1 = rising / idle low |
| irq_ack | input | 1 | Acknowledge strobe, clears the request |
| irq_req | output | 1 | Sticky interrupt request |

## Verification
The bench builds the block with its defaults: PORT_W = 4, NUM_PORTS = 2 and SET_OVER_ACK = 1. With these values, all eight pin indices can be driven one at a time in both polarities, and the mask can split the two ports so that one is an input port and the other an output port. The set-over-acknowledge variant makes the collision case observable as a held request. A table run covers rearm ordering, acknowledging while pins stay active, and configuration changes that would otherwise look like edges. Directed passes cover reset release with an active pin and a sweep over every pin.

// File: rtl/pin_change_pkg.sv
package pin_change_pkg;
   typedef enum logic {
      POL_FALL = 1'b0,
      POL_RISE = 1'b1
   } edge_pol_e;

   localparam logic DIR_IN  = 1'b0;
   localparam logic DIR_OUT = 1'b1;
endpackage

// File: rtl/pcd_port_qualify.sv
module pcd_port_qualify
   import pin_change_pkg::*;
#(
   parameter int PORT_W    = 4,
   parameter int NUM_PORTS = 2,
   localparam int NPINS    = PORT_W * NUM_PORTS
) (
   input  logic [NPINS-1:0]     pin_lvl,
   input  logic [NPINS-1:0]     pin_dir,
   input  logic                 edge_pol,
   output logic [NUM_PORTS-1:0] port_active,
   output logic                 any_active
);
   // A lane is "hot" when it is an input and sits at the active level.
   logic [NPINS-1:0] lane_hot;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      for (genvar b = 0; b < PORT_W; b++) begin : g_bit
         localparam int IDX = p * PORT_W + b;
         always_comb begin
            if (pin_dir[IDX] == DIR_OUT)
               lane_hot[IDX] = 1'b0;
            else if (edge_pol == POL_RISE)
               lane_hot[IDX] = pin_lvl[IDX];
            else
               lane_hot[IDX] = ~pin_lvl[IDX];
         end
      end
      assign port_active[p] = |lane_hot[p*PORT_W +: PORT_W];
   end

   assign any_active = |port_active;
endmodule

// File: rtl/pcd_arm_ctrl.sv
module pcd_arm_ctrl
   import pin_change_pkg::*;
#(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_active,
   input  logic [NPINS-1:0] pin_dir,
   input  logic             edge_pol,
   output logic             fire
);
   logic             armed_q;
   logic [NPINS-1:0] dir_q;
   logic             pol_q;
   logic             cfg_chg;

   assign cfg_chg = (pin_dir != dir_q) || (edge_pol != pol_q);
   assign fire    = any_active && armed_q && !cfg_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         dir_q   <= '0;
         pol_q   <= POL_RISE;
      end else begin
         armed_q <= !any_active;
         dir_q   <= pin_dir;
         pol_q   <= edge_pol;
      end
   end

   AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire); // R3
   AST_FIRE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(rst_n) && !$past(any_active)); // R4
endmodule

// File: rtl/pcd_req_latch.sv
module pcd_req_latch #(
   parameter bit SET_OVER_ACK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic req
);
   logic req_d;

   if (SET_OVER_ACK) begin : g_set_wins
      always_comb begin
         if (set)      req_d = 1'b1;
         else if (ack) req_d = 1'b0;
         else          req_d = req;
      end
      AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
         set |=> req); // R10
   end else begin : g_ack_wins
      always_comb begin
         if (ack)      req_d = 1'b0;
         else if (set) req_d = 1'b1;
         else          req_d = req;
      end
      AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
         set && !ack |=> req); // R2
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= req_d;
   end

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !set |=> !req); // R7
   AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req); // R6
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
   parameter int PORT_W       = 4,
   parameter int NUM_PORTS    = 2,
   parameter bit SET_OVER_ACK = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PORT_W*NUM_PORTS-1:0]   pin_lvl,
   input  logic [PORT_W*NUM_PORTS-1:0]   pin_dir,
   input  logic                          edge_pol,
   input  logic                          irq_ack,
   output logic                          irq_req
);
   localparam int NPINS = PORT_W * NUM_PORTS;

   if (PORT_W < 1) begin : g_bad_width
      $error("PORT_W must be at least 1");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end

   logic [NUM_PORTS-1:0] port_active;
   logic                 any_active;
   logic                 fire;

   pcd_port_qualify #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_qual (
      .pin_lvl    (pin_lvl),
      .pin_dir    (pin_dir),
      .edge_pol   (edge_pol),
      .port_active(port_active),
      .any_active (any_active)
   );

   pcd_arm_ctrl #(.NPINS(NPINS)) u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_active(any_active),
      .pin_dir   (pin_dir),
      .edge_pol  (edge_pol),
      .fire      (fire)
   );

   pcd_req_latch #(.SET_OVER_ACK(SET_OVER_ACK)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (fire),
      .ack  (irq_ack),
      .req  (irq_req)
   );

   AST_CFG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(edge_pol) || !$stable(pin_dir)) && !irq_req |=> !irq_req); // R8
   AST_OUTPUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(pin_lvl & ~pin_dir) && $stable(pin_dir) && $stable(edge_pol)
      && !irq_req |=> !irq_req); // R1
endmodule

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 36;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin_lvl = 8'hFF;
   logic [7:0] pin_dir = 8'h00;
   logic       edge_pol = 1'b0;
   logic       irq_ack = 1'b0;
   logic       irq_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_change_irq u_dut (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_dir(pin_dir),
      .edge_pol(edge_pol), .irq_ack(irq_ack), .irq_req(irq_req)
   );

   // fields: pins, dir, pol, ack, expected irq_req after the edge
   localparam logic [18:0] VEC [NV] = '{
      {8'hFF,8'h00,1'b0,1'b0,1'b0}, // 0  R9 idle after reset
      {8'hFF,8'h00,1'b0,1'b0,1'b0}, // 1
      {8'hFE,8'h00,1'b0,1'b0,1'b1}, // 2  R2 pin0 falls
      {8'hFC,8'h00,1'b0,1'b0,1'b1}, // 3  R6
      {8'hFC,8'h00,1'b0,1'b1,1'b0}, // 4  R7 ack
      {8'hF8,8'h00,1'b0,1'b0,1'b0}, // 5  R3 ignored
      {8'hFE,8'h00,1'b0,1'b0,1'b0}, // 6  R3 partial return
      {8'hEE,8'h00,1'b0,1'b0,1'b0}, // 7  R3 ignored
      {8'hFF,8'h00,1'b0,1'b0,1'b0}, // 8  rearm
      {8'h7F,8'h00,1'b0,1'b0,1'b1}, // 9  R5 pin7
      {8'h7F,8'h00,1'b0,1'b1,1'b0}, // 10 R7 ack while active
      {8'h7F,8'h00,1'b0,1'b0,1'b0}, // 11 R7 no rearm
      {8'hFF,8'h00,1'b0,1'b0,1'b0}, // 12
      {8'hFF,8'h0F,1'b0,1'b0,1'b0}, // 13 R8 dir change
      {8'hF0,8'h0F,1'b0,1'b0,1'b0}, // 14 R1 outputs fall
      {8'hF0,8'h0F,1'b0,1'b0,1'b0}, // 15 R1
      {8'hE0,8'h0F,1'b0,1'b0,1'b1}, // 16 R1 input pin4 falls
      {8'hE0,8'h0F,1'b0,1'b1,1'b0}, // 17
      {8'hFF,8'h00,1'b0,1'b0,1'b0}, // 18
      {8'hFF,8'h00,1'b1,1'b0,1'b0}, // 19 R8 pol change makes active
      {8'hFF,8'h00,1'b1,1'b0,1'b0}, // 20 R8 still disarmed
      {8'h00,8'h00,1'b1,1'b0,1'b0}, // 21 idle low
      {8'h08,8'h00,1'b1,1'b0,1'b1}, // 22 R4 pin3 rises
      {8'h18,8'h00,1'b1,1'b0,1'b1}, // 23 R6
      {8'h10,8'h00,1'b1,1'b1,1'b0}, // 24 R7
      {8'h30,8'h00,1'b1,1'b0,1'b0}, // 25 R4 ignored
      {8'h00,8'h00,1'b1,1'b0,1'b0}, // 26
      {8'h00,8'h00,1'b1,1'b0,1'b0}, // 27
      {8'h01,8'h00,1'b1,1'b1,1'b1}, // 28 R10 set and ack together
      {8'h00,8'h00,1'b1,1'b1,1'b0}, // 29
      {8'h00,8'h00,1'b1,1'b0,1'b0}, // 30
      {8'h40,8'h40,1'b1,1'b0,1'b0}, // 31 R1 output rises
      {8'h40,8'h00,1'b1,1'b0,1'b0}, // 32 R8 dir flips to input while high
      {8'h40,8'h00,1'b1,1'b0,1'b0}, // 33 R8
      {8'h00,8'h00,1'b1,1'b0,1'b0}, // 34
      {8'h04,8'h00,1'b1,1'b0,1'b1}  // 35 R4 pin2 rises
   };

   task automatic check(input logic exp, input string tag);
      n_chk++;
      if (irq_req !== exp) begin
         n_bad++;
         $display("FAIL %s: irq_req=%b expected %b", tag, irq_req, exp);
      end
   endtask

   task automatic step(input logic [7:0] p, input logic [7:0] d, input logic pol,
                       input logic ack, input logic exp, input string tag);
      @(negedge clk);
      pin_lvl = p; pin_dir = d; edge_pol = pol; irq_ack = ack;
      @(posedge clk);
      #(CLK_PERIOD/4);
      check(exp, tag);
   endtask

   task automatic do_reset(input logic [7:0] p, input logic pol);
      @(negedge clk);
      rst_n = 1'b0; pin_lvl = p; pin_dir = 8'h00; edge_pol = pol; irq_ack = 1'b0;
      repeat (3) @(negedge clk);
      check(1'b0, "R9 in reset");
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(1'b0, "R9 reset value");
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][18:11], VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0],
              $sformatf("vector %0d", i));
      end

      // R9: active pin at reset release is not an edge
      do_reset(8'hFE, 1'b0);
      step(8'hFE, 8'h00, 1'b0, 1'b0, 1'b0, "R9 active at release");
      step(8'hFE, 8'h00, 1'b0, 1'b0, 1'b0, "R9 still quiet");
      step(8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, "R9 idle");
      step(8'hFE, 8'h00, 1'b0, 1'b0, 1'b1, "R9 first edge");

      // R5: each pin, both polarities
      step(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, "R5 clear");
      step(8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, "R5 idle");
      for (int k = 0; k < 8; k++) begin
         step(~(8'h01 << k), 8'h00, 1'b0, 1'b0, 1'b1, $sformatf("R5 fall pin %0d", k));
         step(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, $sformatf("R5 fall clear %0d", k));
      end
      step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, "R5 to rise mode");
      step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, "R5 idle low");
      for (int k = 0; k < 8; k++) begin
         step(8'h01 << k, 8'h00, 1'b1, 1'b0, 1'b1, $sformatf("R5 rise pin %0d", k));
         step(8'h00, 8'h00, 1'b1, 1'b1, 1'b0, $sformatf("R5 rise clear %0d", k));
      end

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule